// File: doc/BRIEF.md
# Interrupt-to-MSI Request Aggregator

This block collects up to sixteen level-sensitive interrupt lines from application logic. It turns them into single message-signalled interrupt requests for a link-layer message sender. A request is raised by a 0-to-1 change on any line. Once a request has been raised, the block stays quiet until every line has been low in the same cycle. For that reason, host software must clear every source after each message it receives.

A sticky status vector records which sources produced an edge. The host reads it through a small read port and clears bits by writing ones to them. A mode input that selects DMA operation switches the whole block off. While that input is high, the block raises no requests and latches no status.

Top module: `irq_msi_agg`

## Requirements
- R1: The number of interrupt lines is the parameter N_IRQ, from 1 to 16 (default 16). Status bit i always belongs to line irq_i[i], including the highest line.
- R2: The inputs are registered once. An edge is a 0-to-1 change between two consecutive samples. An edge on any line while the controller is armed raises msi_req_o two clock edges after the input change.
- R3: Once a request has been raised, further edges on any line raise no new request. This lasts until the block re-arms under R5.
- R4: msi_req_o stays high until a cycle in which msi_ack_i is high. Edges that arrive while a request is pending do not queue a second request.
- R5: The controller re-arms only in a cycle where all lines are sampled low and no request is pending. If the lines all go low while a request is still pending, the block does not re-arm.
- R6: Status bit i is sticky and is set by an edge on line i. Pulsing rd_en_i returns the status vector on rd_data_o, with rd_valid_o high, one cycle later.
- R7: A cycle with clr_en_i high clears every status bit whose clr_mask_i bit is 1. If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: While dma_mode_i is high, no request is raised, a pending request is dropped at the next edge, and no status bit is set.
- R9: After reset the status is zero, no request is pending and the controller is armed. Lines that are already high when reset is released do not count as edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_mode_i | input | 1 | High disables the block (DMA operating mode) |
| irq_i | input | N_IRQ | Level interrupt lines |
| msi_req_o | output | 1 | Message request to the sender |
| msi_ack_i | input | 1 | Sender accepts the pending request |
| rd_en_i | input | 1 | Status read strobe |
| rd_data_o | output | N_IRQ | Status read data |
| rd_valid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| clr_en_i | input | 1 | Write-one-to-clear strobe |
| clr_mask_i | input | N_IRQ | Bits to clear in the status |

## Verification
The bench raises new edges while one line is still held high. A design that re-arms on any falling edge instead of on all lines being idle would send a second message there. The lines are also dropped to zero while a request is still unacknowledged, followed by a new edge after the acknowledge. A controller that ignores the pending request when re-arming would raise a spurious message. A clear is timed to land in the same cycle as a set of the same bit, so that a design giving the clear priority loses the interrupt. Reset is released with lines already high, to catch designs that report those lines as fresh edges.

// File: rtl/irq_msi_pkg.sv
package irq_msi_pkg;
  localparam int unsigned MAX_IRQ = 16;

  typedef enum logic {
    CTL_ARMED = 1'b0,
    CTL_QUIET = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int unsigned N_IRQ = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_i,
  output logic [N_IRQ-1:0] smp_o,
  output logic [N_IRQ-1:0] rise_o,
  output logic             all_low_o
);
  logic [N_IRQ-1:0] smp_q, prev_q;
  logic             primed_q;

  // rising edge between two consecutive samples
  function automatic logic [N_IRQ-1:0] edge_up(input logic [N_IRQ-1:0] older,
                                               input logic [N_IRQ-1:0] newer);
    return newer & ~older;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q    <= '0;
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      primed_q <= 1'b1;
      smp_q    <= irq_i;
      // first sample after reset: history equals the sample, so no edge
      prev_q   <= primed_q ? smp_q : irq_i;
    end
  end

  assign smp_o     = smp_q;
  assign rise_o    = edge_up(prev_q, smp_q);
  assign all_low_o = (smp_q == '0);
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int unsigned N_IRQ = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] set_i,
  input  logic             clr_en_i,
  input  logic [N_IRQ-1:0] clr_mask_i,
  input  logic             rd_en_i,
  output logic [N_IRQ-1:0] status_o,
  output logic [N_IRQ-1:0] rd_data_o,
  output logic             rd_valid_o
);
  logic [N_IRQ-1:0] status_q, rd_q;
  logic             rdv_q;
  logic [N_IRQ-1:0] clr_eff;

  // set takes priority over clear
  function automatic logic [N_IRQ-1:0] sticky_next(input logic [N_IRQ-1:0] cur,
                                                   input logic [N_IRQ-1:0] set,
                                                   input logic [N_IRQ-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  assign clr_eff = clr_en_i ? clr_mask_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      rd_q     <= '0;
      rdv_q    <= 1'b0;
    end else begin
      status_q <= sticky_next(status_q, set_i, clr_eff);
      rdv_q    <= rd_en_i;
      if (rd_en_i) rd_q <= status_q;
    end
  end

  assign status_o   = status_q;
  assign rd_data_o  = rd_q;
  assign rd_valid_o = rdv_q;
endmodule

// File: rtl/msi_ctrl.sv
module msi_ctrl
  import irq_msi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic any_rise_i,
  input  logic all_low_i,
  input  logic ack_i,
  output logic req_o,
  output logic armed_o
);
  ctl_state_e state_q, state_d;
  logic       req_q, req_d;

  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    if (!en_i) begin
      state_d = CTL_ARMED;
      req_d   = 1'b0;
    end else begin
      unique case (state_q)
        CTL_ARMED: begin
          if (any_rise_i) begin
            req_d   = 1'b1;
            state_d = CTL_QUIET;
          end
        end
        CTL_QUIET: begin
          if (req_q && ack_i) req_d = 1'b0;
          if (all_low_i && !req_q) state_d = CTL_ARMED;
        end
        default: state_d = CTL_ARMED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CTL_ARMED;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
    end
  end

  assign req_o   = req_q;
  assign armed_o = (state_q == CTL_ARMED);
endmodule

// File: rtl/irq_msi_agg.sv
module irq_msi_agg #(
  parameter int unsigned N_IRQ = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dma_mode_i,
  input  logic [N_IRQ-1:0] irq_i,
  output logic             msi_req_o,
  input  logic             msi_ack_i,
  input  logic             rd_en_i,
  output logic [N_IRQ-1:0] rd_data_o,
  output logic             rd_valid_o,
  input  logic             clr_en_i,
  input  logic [N_IRQ-1:0] clr_mask_i
);
  logic [N_IRQ-1:0] smp_w, rise_w, qual_rise_w, status_w;
  logic             all_low_w, any_rise_w, armed_w;

  assign qual_rise_w = dma_mode_i ? '0 : rise_w;
  assign any_rise_w  = |qual_rise_w;

  irq_sampler #(.N_IRQ(N_IRQ)) u_smp (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
    .smp_o(smp_w), .rise_o(rise_w), .all_low_o(all_low_w)
  );

  irq_status #(.N_IRQ(N_IRQ)) u_sts (
    .clk(clk), .rst_n(rst_n), .set_i(qual_rise_w),
    .clr_en_i(clr_en_i), .clr_mask_i(clr_mask_i), .rd_en_i(rd_en_i),
    .status_o(status_w), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
  );

  msi_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n), .en_i(!dma_mode_i), .any_rise_i(any_rise_w),
    .all_low_i(all_low_w), .ack_i(msi_ack_i), .req_o(msi_req_o), .armed_o(armed_w)
  );
endmodule

// File: rtl/irq_msi_agg_chk.sv
module irq_msi_agg_chk #(
  parameter int unsigned N_IRQ = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dma_mode_i,
  input logic             msi_req_o,
  input logic             msi_ack_i,
  input logic             rd_en_i,
  input logic             rd_valid_o,
  input logic             clr_en_i,
  input logic [N_IRQ-1:0] clr_mask_i,
  input logic [N_IRQ-1:0] qual_rise_w,
  input logic [N_IRQ-1:0] status_w,
  input logic             all_low_w,
  input logic             armed_w
);
  assert_req_from_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msi_req_o) |-> $past(|qual_rise_w));

  assert_no_req_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msi_req_o) |-> $past(armed_w));

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_req_o && !msi_ack_i && !dma_mode_i) |=> msi_req_o);

  assert_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_w && !$past(armed_w)) |-> (($past(all_low_w) && !$past(msi_req_o)) || $past(dma_mode_i)));

  assert_status_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|qual_rise_w) |=> ((status_w & $past(qual_rise_w)) == $past(qual_rise_w)));

  assert_rd_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en_i |=> ((status_w & $past(clr_mask_i & ~qual_rise_w)) == '0));

  assert_dma_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_mode_i |=> !msi_req_o);
endmodule

bind irq_msi_agg irq_msi_agg_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_mode_i(dma_mode_i), .msi_req_o(msi_req_o),
  .msi_ack_i(msi_ack_i), .rd_en_i(rd_en_i), .rd_valid_o(rd_valid_o),
  .clr_en_i(clr_en_i), .clr_mask_i(clr_mask_i), .qual_rise_w(qual_rise_w),
  .status_w(status_w), .all_low_w(all_low_w), .armed_w(armed_w)
);

// File: tb/irq_msi_agg_test.sv
`timescale 1ns/1ps
module irq_msi_agg_test;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dma = 1'b0;
  logic [N-1:0] irq = '0;
  logic         req;
  logic         ack = 1'b0;
  logic         rd_en = 1'b0;
  logic [N-1:0] rd_data;
  logic         rd_valid;
  logic         clr_en = 1'b0;
  logic [N-1:0] clr_mask = '0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [N-1:0] exp_q[$];
  string        tag_q[$];

  always #5 clk = ~clk;

  irq_msi_agg #(.N_IRQ(N)) uut (
    .clk(clk), .rst_n(rst_n), .dma_mode_i(dma), .irq_i(irq), .msi_req_o(req),
    .msi_ack_i(ack), .rd_en_i(rd_en), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .clr_en_i(clr_en), .clr_mask_i(clr_mask)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_req(input string tag, input logic exp);
    total++;
    if (req !== exp) begin
      bad++;
      $display("FAIL %s msi_req actual=%b expected=%b", tag, req, exp);
    end
  endtask

  // driver: queue the expected status, then strobe a read
  task automatic read_expect(input string tag, input logic [N-1:0] v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
    rd_en = 1'b1;
    tick(1);
    rd_en = 1'b0;
  endtask

  task automatic clear(input logic [N-1:0] m);
    clr_en = 1'b1; clr_mask = m;
    tick(1);
    clr_en = 1'b0; clr_mask = '0;
  endtask

  task automatic acknowledge();
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  // monitor: compare each read result against the queue
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R6 unexpected read actual=%h expected=none", rd_data);
      end else begin
        automatic logic [N-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_data !== e) begin
          bad++;
          $display("FAIL %s status actual=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R9 reset state
    chk_req("R9", 1'b0);
    read_expect("R9", 16'h0000);

    // R2 edge on line 0, two-edge latency
    irq[0] = 1'b1;
    tick(1); chk_req("R2", 1'b0);
    tick(1); chk_req("R2", 1'b1);
    read_expect("R6", 16'h0001);

    // R4 held while pending, new edge only sets status
    irq[3] = 1'b1;
    tick(2); chk_req("R4", 1'b1);
    read_expect("R4", 16'h0009);
    acknowledge();
    chk_req("R4", 1'b0);

    // R3 edge while line 0 still high
    irq[5] = 1'b1;
    tick(4); chk_req("R3", 1'b0);
    read_expect("R3", 16'h0029);

    // R7 clear and set-wins
    clear(16'h0009);
    read_expect("R7", 16'h0020);
    irq[1] = 1'b1;
    tick(1);
    clear(16'h0002);
    read_expect("R7", 16'h0022);

    // R3 toggling one line while others stay high
    irq[0] = 1'b0; tick(2);
    irq[0] = 1'b1; tick(3);
    chk_req("R3", 1'b0);

    // R5 all low re-arms
    irq = '0; tick(2);
    irq[2] = 1'b1; tick(2);
    chk_req("R5", 1'b1);

    // R5 all low while still pending does not re-arm
    irq = '0; tick(3);
    irq[6] = 1'b1; tick(3);
    chk_req("R4", 1'b1);
    acknowledge();
    irq[7] = 1'b1; tick(3);
    chk_req("R5", 1'b0);
    irq = '0; tick(3);
    clear('1);

    // R8 DMA mode disables
    dma = 1'b1;
    irq[4] = 1'b1; tick(3);
    chk_req("R8", 1'b0);
    read_expect("R8", 16'h0000);
    irq = '0; dma = 1'b0; tick(3);
    irq[4] = 1'b1; tick(2);
    chk_req("R8", 1'b1);
    dma = 1'b1; tick(1);
    chk_req("R8", 1'b0);
    irq = '0; tick(2);
    dma = 1'b0;
    clear('1);
    tick(2);

    // R1 highest line
    irq[15] = 1'b1; tick(2);
    chk_req("R1", 1'b1);
    read_expect("R1", 16'h8000);
    acknowledge();

    // R9 lines high across reset
    irq[7] = 1'b1;
    rst_n = 1'b0; tick(2);
    rst_n = 1'b1; tick(4);
    chk_req("R9", 1'b0);
    read_expect("R9", 16'h0000);

    tick(3);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R6 missing reads actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule